// File: doc/BRIEF.md
# Binary Trigger-Wave Propagation Grid

This block is a rectangular array of cells that spreads a binary activity wave for global morphology, such as filling holes inside closed outlines or rebuilding objects from seed pixels. Every cell keeps three bits:
- a membership bit that says whether the wave may pass through it;
- a seed bit;
- a triggered bit.

Every cell also holds a gating flag. The wave starts at the seeds and moves through the member cells. A cell takes it up from any of its four neighbours when its own direction-enable mask allows that neighbour. Cells that are not members block the wave, so regions enclosed by a closed outline of non-members stay untriggered.

Work follows a fixed order: clear, load the membership image, load the seeds, then run. The flag decides which cells accept the membership and seed loads. During a run the grid advances one neighbour step per clock. It reports completion in the first cycle in which no cell changes. The inverted result can then be copied into the flag of every cell, so that the pixels the wave did not reach become the active set for later work. The direction masks come from a per-cell bus. Because each pixel picks its own enabled directions, both the direction and the connectivity of the spread can vary across the image.

Top module: `trigger_wave_grid`

## Requirements
- R1: After reset all triggered bits are 0, all flags are 1, `busy_o` is 0 and `done_o` is 0. Commands on `op_i` are 0 none, 1 clear, 2 load membership, 3 load seeds, 4 run, 5 load flags, 6 flag from result. Cell index is row*COLS+column.
- R2: Load membership (2) copies `space_i` into the membership bit of exactly those cells whose flag is 1. It is accepted only after a clear or after another membership load, and is ignored once seeds have been loaded.
- R3: Load seeds (3) copies `mark_i` only in cells whose flag is 1. A seed offered to a cell outside the membership is ignored.
- R4: Phase order is enforced. Load seeds issued before any membership load is ignored. Run issued before a seed load is ignored and leaves `busy_o` at 0.
- R5: A cell becomes triggered only if it is a member and either is a seed or has a triggered neighbour whose direction is enabled in the cell's own mask. The mask is `mask_i[4*i+3:4*i]`: bit 0 enables the neighbour in the row above, bit 1 the next column, bit 2 the row below, bit 3 the previous column. Triggered bits stay set until a clear.
- R6: Non-member cells never trigger and stop the wave, so member cells enclosed by a closed outline of non-members stay untriggered.
- R7: A cell on the grid edge treats a missing neighbour as untriggered. The wave never wraps between rows or between opposite edges.
- R8: A run advances one neighbour step per clock. Seeds trigger on the first clock after the run command, and a cell d steps from a seed triggers d clocks later. `busy_o` is 1 while running. `done_o` rises on the first clock at which no cell changed and stays high until a clear.
- R9: Load flags (5) copies `flag_i` into all flags and is ignored while running. Flag from result (6) loads each flag with the inverse of its triggered bit and is accepted only after completion.
- R10: Clear (1) zeroes membership, seeds and triggered bits and drops `done_o`, in any phase. The flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Command code, held for one cycle per command |
| space_i | input | ROWS*COLS | Membership image for load membership |
| mark_i | input | ROWS*COLS | Seed image for load seeds |
| flag_i | input | ROWS*COLS | Flag image for load flags |
| mask_i | input | 4*ROWS*COLS | Per-cell direction-enable masks, four bits per cell |
| trig_o | output | ROWS*COLS | Triggered bit of every cell |
| flag_o | output | ROWS*COLS | Flag of every cell |
| busy_o | output | 1 | Propagation in progress |
| done_o | output | 1 | Propagation complete, result stable |

## Verification
The bench builds the grid with 7 rows and 9 columns rather than the square-free default. An odd, unequal shape means that the last cell of one row and the first cell of the next are adjacent in the flat index while not being neighbours in the grid. This exposes any wrap between rows, and a transposed row/column index would also show up. Nine columns give a straight chain long enough to check that each step takes exactly one clock and that completion lands one clock after the last change. Seven rows leave room for random nested outlines whose enclosed holes are compared against a software flood fill.

// File: rtl/twg_pkg.sv
package twg_pkg;

    typedef enum logic [2:0] {
        OP_NOP         = 3'd0,
        OP_CLEAR       = 3'd1,
        OP_LOAD_SPACE  = 3'd2,
        OP_LOAD_MARK   = 3'd3,
        OP_RUN         = 3'd4,
        OP_FLAG_LOAD   = 3'd5,
        OP_FLAG_RESULT = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        PH_CLEARED = 3'd0,
        PH_SPACED  = 3'd1,
        PH_MARKED  = 3'd2,
        PH_RUNNING = 3'd3,
        PH_DONE    = 3'd4
    } phase_e;

    localparam int NDIR  = 4;
    localparam int DIR_N = 0;
    localparam int DIR_E = 1;
    localparam int DIR_S = 2;
    localparam int DIR_W = 3;

    typedef struct packed {
        logic clr;
        logic ld_space;
        logic ld_mark;
        logic step;
        logic flag_ld;
        logic flag_res;
    } cell_ctl_t;

    function automatic logic space_load_ok(phase_e ph);
        return (ph == PH_CLEARED) || (ph == PH_SPACED);
    endfunction

    function automatic logic mark_load_ok(phase_e ph);
        return (ph == PH_SPACED) || (ph == PH_MARKED);
    endfunction

endpackage

// File: rtl/twg_phase_ctrl.sv
module twg_phase_ctrl
    import twg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] op_i,
    input  logic       any_change,
    output cell_ctl_t  ctl_o,
    output logic       busy_o,
    output logic       done_o
);

    phase_e phase_q, phase_d;
    op_e    op;

    assign op = op_e'(op_i);

    always_comb begin
        ctl_o   = '0;
        phase_d = phase_q;
        if (op == OP_CLEAR) begin
            ctl_o.clr = 1'b1;
            phase_d   = PH_CLEARED;
        end else if (phase_q == PH_RUNNING) begin
            ctl_o.step = 1'b1;
            if (!any_change) begin
                phase_d = PH_DONE;
            end
        end else begin
            case (op)
                OP_LOAD_SPACE: begin
                    if (space_load_ok(phase_q)) begin
                        ctl_o.ld_space = 1'b1;
                        phase_d        = PH_SPACED;
                    end
                end
                OP_LOAD_MARK: begin
                    if (mark_load_ok(phase_q)) begin
                        ctl_o.ld_mark = 1'b1;
                        phase_d       = PH_MARKED;
                    end
                end
                OP_RUN: begin
                    if (phase_q == PH_MARKED) begin
                        phase_d = PH_RUNNING;
                    end
                end
                OP_FLAG_LOAD:   ctl_o.flag_ld = 1'b1;
                OP_FLAG_RESULT: ctl_o.flag_res = (phase_q == PH_DONE);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_CLEARED;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign busy_o = (phase_q == PH_RUNNING);
    assign done_o = (phase_q == PH_DONE);

    AST_RUN_AFTER_MARKS: assert property (@(posedge clk) disable iff (rst) (phase_q == PH_RUNNING && $past(phase_q) != PH_RUNNING) |-> $past(phase_q) == PH_MARKED); // R4
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) (done_o && op != OP_CLEAR) |=> done_o); // R8
    AST_CLEAR_DROPS_DONE: assert property (@(posedge clk) disable iff (rst) (op == OP_CLEAR) |=> (!done_o && !busy_o)); // R10
    AST_NO_SPACE_AFTER_MARKS: assert property (@(posedge clk) disable iff (rst) (phase_q == PH_MARKED && op != OP_CLEAR) |=> phase_q != PH_SPACED); // R2

endmodule

// File: rtl/twg_cell.sv
module twg_cell
    import twg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  cell_ctl_t       ctl_i,
    input  logic            space_in,
    input  logic            mark_in,
    input  logic            flag_in,
    input  logic [NDIR-1:0] mask_i,
    input  logic [NDIR-1:0] nbr_i,
    output logic            trig_o,
    output logic            flag_o,
    output logic            rise_o
);

    logic space_q, mark_q, trig_q, flag_q;
    logic wave_in, cand;

    assign wave_in = |(mask_i & nbr_i);
    assign cand    = space_q & (mark_q | wave_in);
    assign rise_o  = cand & ~trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            space_q <= 1'b0;
            mark_q  <= 1'b0;
            trig_q  <= 1'b0;
            flag_q  <= 1'b1;
        end else begin
            if (ctl_i.clr) begin
                space_q <= 1'b0;
                mark_q  <= 1'b0;
                trig_q  <= 1'b0;
            end
            if (ctl_i.ld_space && flag_q) begin
                space_q <= space_in;
            end
            if (ctl_i.ld_mark && flag_q) begin
                mark_q <= mark_in & space_q;
            end
            if (ctl_i.step) begin
                trig_q <= trig_q | cand;
            end
            if (ctl_i.flag_ld) begin
                flag_q <= flag_in;
            end else if (ctl_i.flag_res) begin
                flag_q <= ~trig_q;
            end
        end
    end

    assign trig_o = trig_q;
    assign flag_o = flag_q;

    AST_MARK_IN_SPACE: assert property (@(posedge clk) disable iff (rst) mark_q |-> space_q); // R3
    AST_TRIG_IN_SPACE: assert property (@(posedge clk) disable iff (rst) trig_q |-> space_q); // R6
    AST_TRIG_HOLDS: assert property (@(posedge clk) disable iff (rst) (trig_q && !ctl_i.clr) |=> trig_q); // R5
    AST_TRIG_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst) (!ctl_i.step && !ctl_i.clr) |=> $stable(trig_q)); // R8
    AST_FLAG_KEPT: assert property (@(posedge clk) disable iff (rst) (!ctl_i.flag_ld && !ctl_i.flag_res) |=> $stable(flag_q)); // R10

endmodule

// File: rtl/trigger_wave_grid.sv
module trigger_wave_grid
    import twg_pkg::*;
#(
    parameter int ROWS = 6,
    parameter int COLS = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [2:0]                op_i,
    input  logic [ROWS*COLS-1:0]      space_i,
    input  logic [ROWS*COLS-1:0]      mark_i,
    input  logic [ROWS*COLS-1:0]      flag_i,
    input  logic [NDIR*ROWS*COLS-1:0] mask_i,
    output logic [ROWS*COLS-1:0]      trig_o,
    output logic [ROWS*COLS-1:0]      flag_o,
    output logic                      busy_o,
    output logic                      done_o
);

    localparam int CELLS = ROWS * COLS;

    cell_ctl_t        ctl;
    logic [CELLS-1:0] trig_w;
    logic [CELLS-1:0] flag_w;
    logic [CELLS-1:0] rise_w;
    logic             any_change;

    assign any_change = |rise_w;

    twg_phase_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .op_i       (op_i),
        .any_change (any_change),
        .ctl_o      (ctl),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            logic [NDIR-1:0] nbr;

            if (r > 0) begin : g_n
                assign nbr[DIR_N] = trig_w[IDX - COLS];
            end else begin : g_n_edge
                assign nbr[DIR_N] = 1'b0;
            end
            if (c < COLS - 1) begin : g_e
                assign nbr[DIR_E] = trig_w[IDX + 1];
            end else begin : g_e_edge
                assign nbr[DIR_E] = 1'b0;
            end
            if (r < ROWS - 1) begin : g_s
                assign nbr[DIR_S] = trig_w[IDX + COLS];
            end else begin : g_s_edge
                assign nbr[DIR_S] = 1'b0;
            end
            if (c > 0) begin : g_w
                assign nbr[DIR_W] = trig_w[IDX - 1];
            end else begin : g_w_edge
                assign nbr[DIR_W] = 1'b0;
            end

            twg_cell u_cell (
                .clk      (clk),
                .rst      (rst),
                .ctl_i    (ctl),
                .space_in (space_i[IDX]),
                .mark_in  (mark_i[IDX]),
                .flag_in  (flag_i[IDX]),
                .mask_i   (mask_i[NDIR*IDX +: NDIR]),
                .nbr_i    (nbr),
                .trig_o   (trig_w[IDX]),
                .flag_o   (flag_w[IDX]),
                .rise_o   (rise_w[IDX])
            );
        end
    end

    assign trig_o = trig_w;
    assign flag_o = flag_w;

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst) !(busy_o && done_o)); // R8
    AST_DONE_NEEDS_QUIET: assert property (@(posedge clk) disable iff (rst) (busy_o && !$past(busy_o)) |-> !done_o); // R8
    AST_TRIG_FROZEN_IDLE: assert property (@(posedge clk) disable iff (rst) (!busy_o && $past(!busy_o) && $past(op_i) != 3'd1) |-> $stable(trig_o)); // R8

endmodule

// File: tb/trigger_wave_grid_test.sv
module trigger_wave_grid_test;

    localparam int R = 7;
    localparam int C = 9;
    localparam int N = R * C;

    localparam logic [2:0] K_NOP = 3'd0, K_CLEAR = 3'd1, K_SPACE = 3'd2, K_MARK = 3'd3,
                           K_RUN = 3'd4, K_FLAG = 3'd5, K_FRES = 3'd6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [2:0]     op_i = K_NOP;
    logic [N-1:0]   space_i = '0;
    logic [N-1:0]   mark_i = '0;
    logic [N-1:0]   flag_i = '0;
    logic [4*N-1:0] mask_i = '0;
    logic [N-1:0]   trig_o, flag_o;
    logic           busy_o, done_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    trigger_wave_grid #(.ROWS(R), .COLS(C)) uut (
        .clk(clk), .rst(rst), .op_i(op_i), .space_i(space_i), .mark_i(mark_i),
        .flag_i(flag_i), .mask_i(mask_i), .trig_o(trig_o), .flag_o(flag_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    function automatic int at(int r, int c);
        return r * C + c;
    endfunction

    function automatic logic [4*N-1:0] mask_all(logic [3:0] m);
        logic [4*N-1:0] v;
        for (int i = 0; i < N; i++) v[4*i +: 4] = m;
        return v;
    endfunction

    function automatic logic [N-1:0] row_bits(int r);
        logic [N-1:0] v = '0;
        for (int c = 0; c < C; c++) v[at(r, c)] = 1'b1;
        return v;
    endfunction

    // Software flood fill following the triggering rule of R5, R6 and R7
    function automatic logic [N-1:0] ref_fill(logic [N-1:0] sp, logic [N-1:0] mk, logic [4*N-1:0] mk4);
        logic [N-1:0] t, nx;
        t = sp & mk;
        for (int it = 0; it < N + 2; it++) begin
            nx = t;
            for (int r = 0; r < R; r++) begin
                for (int c = 0; c < C; c++) begin
                    int  i = at(r, c);
                    logic hit = 1'b0;
                    if (r > 0     && mk4[4*i+0] && t[at(r-1, c)]) hit = 1'b1;
                    if (c < C - 1 && mk4[4*i+1] && t[at(r, c+1)]) hit = 1'b1;
                    if (r < R - 1 && mk4[4*i+2] && t[at(r+1, c)]) hit = 1'b1;
                    if (c > 0     && mk4[4*i+3] && t[at(r, c-1)]) hit = 1'b1;
                    if (sp[i] && hit) nx[i] = 1'b1;
                end
            end
            t = nx;
        end
        return t;
    endfunction

    task automatic chk_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] k);
        @(negedge clk);
        op_i = k;
        @(negedge clk);
        op_i = K_NOP;
    endtask

    task automatic prep(input logic [N-1:0] sp, input logic [N-1:0] mk, input logic [4*N-1:0] m4);
        flag_i = '1;
        do_op(K_FLAG);
        do_op(K_CLEAR);
        space_i = sp;
        do_op(K_SPACE);
        mark_i = mk;
        do_op(K_MARK);
        mask_i = m4;
    endtask

    task automatic run_wait();
        do_op(K_RUN);
        for (int k = 0; k < 4 * N && !done_o; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk_vec("R1 trig after reset", trig_o, '0);
        chk_vec("R1 flags after reset", flag_o, '1);
        chk_bit("R1 busy after reset", busy_o, 1'b0);
        chk_bit("R1 done after reset", done_o, 1'b0);
    endtask

    task automatic t_phase_order();
        flag_i = '1;
        do_op(K_FLAG);
        do_op(K_CLEAR);
        mark_i = '1;
        do_op(K_MARK);          // R4: no membership yet, ignored
        do_op(K_RUN);           // R4: ignored
        chk_bit("R4 run before seeds ignored", busy_o, 1'b0);
        space_i = row_bits(0);
        do_op(K_SPACE);
        do_op(K_RUN);           // still no seeds
        chk_bit("R4 run after membership only ignored", busy_o, 1'b0);
        mark_i = '0;
        do_op(K_MARK);
        space_i = '1;
        do_op(K_SPACE);         // R2: after seeds, ignored
        mark_i = '1;
        do_op(K_MARK);
        mask_i = '0;
        run_wait();
        chk_vec("R2 late membership load ignored", trig_o, row_bits(0));
    endtask

    task automatic t_flag_gates_space();
        logic [N-1:0] chk = '0;
        for (int i = 0; i < N; i++) chk[i] = ((i / C) + (i % C)) % 2 == 0;
        do_op(K_CLEAR);
        flag_i = chk;
        do_op(K_FLAG);
        chk_vec("R9 flag load", flag_o, chk);
        space_i = '1;
        do_op(K_SPACE);
        flag_i = '1;
        do_op(K_FLAG);
        mark_i = '1;
        do_op(K_MARK);
        mask_i = '0;
        run_wait();
        chk_vec("R2 membership gated by flag", trig_o, chk);
    endtask

    task automatic t_mark_gating();
        logic [N-1:0] left = '0, even = '0;
        for (int i = 0; i < N; i++) begin
            left[i] = (i % C) < C / 2;
            even[i] = ((i / C) % 2) == 0;
        end
        flag_i = '1;
        do_op(K_FLAG);
        do_op(K_CLEAR);
        space_i = left;
        do_op(K_SPACE);
        flag_i = even;
        do_op(K_FLAG);
        mark_i = '1;
        do_op(K_MARK);
        mask_i = '0;
        run_wait();
        chk_vec("R3 seeds gated by flag and membership", trig_o, left & even);
    endtask

    task automatic t_chain_timing();
        logic [N-1:0] sd = '0;
        sd[at(0, 0)] = 1'b1;
        prep(row_bits(0), sd, mask_all(4'b1000));
        do_op(K_RUN);
        @(negedge clk);
        chk_bit("R8 busy during run", busy_o, 1'b1);
        @(negedge clk);
        chk_vec("R8 two steps after run", trig_o, N'(3));
        for (int k = 2; k < C; k++) @(negedge clk);
        chk_bit("R8 done not before quiet clock", done_o, 1'b0);
        @(negedge clk);
        chk_bit("R8 done on first quiet clock", done_o, 1'b1);
        chk_vec("R8 chain fully triggered", trig_o, row_bits(0));
    endtask

    task automatic t_mask_dir();
        logic [N-1:0] sd = '0, ex = '0;
        sd[at(0, 0)] = 1'b1;
        ex[at(0, 0)] = 1'b1;
        prep(row_bits(0), sd, mask_all(4'b0010));
        run_wait();
        chk_vec("R5 next-column mask does not pull from west", trig_o, ex);
        sd = '0;
        sd[at(0, C-1)] = 1'b1;
        prep(row_bits(0), sd, mask_all(4'b0010));
        run_wait();
        chk_vec("R5 next-column mask spreads westward", trig_o, row_bits(0));
        for (int t = 0; t < 3; t++) begin
            logic [N-1:0]   sp, mk;
            logic [4*N-1:0] m4;
            for (int i = 0; i < N; i++) begin
                sp[i] = ($urandom_range(0, 9) < 8);
                mk[i] = ($urandom_range(0, 19) == 0);
                m4[4*i +: 4] = 4'($urandom_range(0, 15));
            end
            prep(sp, mk, m4);
            run_wait();
            chk_vec("R5 random masks vs reference", trig_o, ref_fill(sp, mk, m4));
        end
    endtask

    task automatic t_border();
        logic [N-1:0] sp = '0, sd = '0;
        sp[at(0, C-1)] = 1'b1;
        sp[at(1, 0)] = 1'b1;
        sd[at(0, C-1)] = 1'b1;
        prep(sp, sd, mask_all(4'b1111));
        run_wait();
        chk_vec("R7 no wrap between rows", trig_o, sd);
        sp = '0;
        sd = '0;
        sp[at(0, 0)] = 1'b1;
        sp[at(R-1, 0)] = 1'b1;
        sd[at(0, 0)] = 1'b1;
        prep(sp, sd, mask_all(4'b1111));
        run_wait();
        chk_vec("R7 no wrap top to bottom", trig_o, sd);
    endtask

    task automatic t_holes();
        logic [N-1:0] sp, sd, ex;
        // fixed closed outline rows 1..5, cols 1..5
        sp = '1;
        for (int r = 1; r <= 5; r++)
            for (int c = 1; c <= 5; c++)
                if (r == 1 || r == 5 || c == 1 || c == 5) sp[at(r, c)] = 1'b0;
        sd = '0;
        sd[at(0, 0)] = 1'b1;
        prep(sp, sd, mask_all(4'b1111));
        run_wait();
        ex = sp;
        for (int r = 2; r <= 4; r++)
            for (int c = 2; c <= 4; c++) ex[at(r, c)] = 1'b0;
        chk_vec("R6 enclosed hole untriggered", trig_o, ex);
        for (int t = 0; t < 4; t++) begin
            sp = '1;
            for (int b = 0; b < 3; b++) begin
                int r0 = $urandom_range(0, R - 3);
                int c0 = $urandom_range(0, C - 3);
                int r1 = $urandom_range(r0 + 2, R - 1);
                int c1 = $urandom_range(c0 + 2, C - 1);
                for (int r = r0; r <= r1; r++)
                    for (int c = c0; c <= c1; c++)
                        if (r == r0 || r == r1 || c == c0 || c == c1) sp[at(r, c)] = 1'b0;
            end
            sd = '0;
            for (int r = 0; r < R; r++)
                for (int c = 0; c < C; c++)
                    if (r == 0 || r == R - 1 || c == 0 || c == C - 1) sd[at(r, c)] = sp[at(r, c)];
            prep(sp, sd, mask_all(4'b1111));
            run_wait();
            chk_vec("R6 random outlines vs flood fill", trig_o, ref_fill(sp, sd, mask_all(4'b1111)));
        end
    endtask

    task automatic t_flag_result();
        logic [N-1:0] res;
        res = trig_o;
        do_op(K_FRES);
        chk_vec("R9 flag from inverted result", flag_o, ~res);
        do_op(K_CLEAR);
        flag_i = '1;
        do_op(K_FLAG);
        do_op(K_FRES);          // not done: ignored
        chk_vec("R9 flag from result ignored before completion", flag_o, '1);
    endtask

    task automatic t_clear();
        logic [N-1:0] pat = '0;
        prep('1, N'(1), mask_all(4'b1111));
        run_wait();
        for (int i = 0; i < N; i += 3) pat[i] = 1'b1;
        flag_i = pat;
        do_op(K_FLAG);
        do_op(K_CLEAR);
        chk_vec("R10 clear zeroes triggered bits", trig_o, '0);
        chk_vec("R10 clear keeps flags", flag_o, pat);
        chk_bit("R10 clear drops done", done_o, 1'b0);
        do_op(K_RUN);
        chk_bit("R10 run after clear ignored", busy_o, 1'b0);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_phase_order();
        t_flag_gates_space();
        t_mark_gating();
        t_chain_timing();
        t_mask_dir();
        t_border();
        t_holes();
        t_flag_result();
        t_clear();
        finish_up();
    end

endmodule